// File: doc/BRIEF.md
# Phase Accumulator Synthesis Core

This block is the clocked heart of a numerically controlled oscillator. A 28-bit accumulator advances on every rising edge of the core clock by one of two stored tuning words. One of two stored 12-bit phase offsets is added to the upper bits of the accumulator, and the sum is truncated to a 12-bit phase word for a downstream sine lookup. A square output is taken from the most significant bit of that phase word. It can optionally run at half frequency, and it is only driven when enabled.

A serial loader in front of the block delivers whole register words as single-cycle write strobes with an address. The two select pins choose the active tuning word and phase offset without any register write. A fixed output pipeline gives every change a known latency. The control word carries a hold bit and a sleep bit. The hold bit parks the accumulator and blanks the outputs, leaving every stored word intact. The sleep bit freezes the whole datapath in place. The control word is taken into the core on the falling edge of the clock, so a control write acts from the rising edge after the write edge.

Top module: `nco_phase_core`

## Requirements
- R1: While `arst_n` is low and after it rises, all stored words are zero, the control word has only its hold bit set, and `phase_out` and `sq_out` read 0 until a control write clears hold.
- R2: A write with `wr_en` high stores `wr_data` at the rising edge. Address 0 is control, 1 and 2 are tuning words 0 and 1 (28 bits), and 3 and 4 are phase offsets 0 and 1 (low 12 bits). Writes to addresses 5 to 7 change no register and no output.
- R3: Each rising edge adds the tuning word chosen by `fsel` to the accumulator. `phase_out` is the accumulator's bits 27:16 plus the phase offset chosen by `psel`, modulo 4096, so a tuning word of 0x10000 raises `phase_out` by exactly 1 per cycle.
- R4: A change on `fsel` sampled at some rising edge first shows on `phase_out` after the seventh rising edge, counting the sampling edge as the first.
- R5: A change on `psel` first shows on `phase_out` after the seventh rising edge, counting the sampling edge as the first.
- R6: A write to the selected phase offset shows after the seventh rising edge, counting the write edge as the first. A write to the selected tuning word first shows after the eighth. A write to an unselected register has no effect on the output.
- R7: Control bit 0 (hold) zeroes the accumulator and forces `phase_out` and `sq_out` to 0 from the rising edge after its write edge. The tuning, phase and control words keep their contents.
- R8: After a control write clears hold at edge k, the outputs stay 0 through edge k+6. From edge k+7 they show the selected offset plus one step of the selected tuning word.
- R9: Control bits are captured on the falling clock edge. While control bit 1 (sleep) is set, the accumulator and output pipeline hold still from the rising edge after its write edge. After sleep is cleared, the output continues one step per cycle from the frozen value, and the first step comes after the second rising edge counting the clearing write edge as the first.
- R10: `sq_out` is the MSB of the phase sum, passed through the same pipeline as `phase_out`. It is 0 whenever control bit 2 (square enable) is clear.
- R11: With control bit 3 (divide-by-two) set, `sq_out` toggles on each rising transition of the phase MSB and so runs at half the frequency, with 50% duty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| arst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en | input | 1 | Register write strobe from the serial loader |
| wr_addr | input | 3 | Target register of the write |
| wr_data | input | 28 | Write data (phase offsets use bits 11:0, control uses bits 3:0) |
| fsel | input | 1 | Tuning word select |
| psel | input | 1 | Phase offset select |
| phase_out | output | 12 | Truncated phase word |
| sq_out | output | 1 | Square output |

## Verification
The select pins, the phase offset writes and the hold release are due after the seventh rising edge that follows their sampling edge, and a tuning word write after the eighth. For each of these, the bench checks the old value after the sixth edge and the new value exactly on the due edge, so a stage added to or dropped from any path shows up. Hold blanks the outputs one edge after its write, and sleep freezes them from the same point. Both are checked on the edge after the control write and again several edges later. The square output is judged over windows of 64 cycles by its high count and its longest high run, which do not depend on the phase at which the window starts.

// File: rtl/nco_pkg.sv
`timescale 1ns/1ps
package nco_pkg;
  localparam int NUM_SEL = 2;
  localparam int ADDR_W  = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_FREQ0  = 3'd1;
  localparam logic [ADDR_W-1:0] A_PHASE0 = 3'd3;
  localparam logic [ADDR_W-1:0] A_LAST   = 3'd4;

  typedef struct packed {
    logic div2;    // bit 3
    logic sq_en;   // bit 2
    logic sleep;   // bit 1
    logic hold;    // bit 0
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{div2: 1'b0, sq_en: 1'b0, sleep: 1'b0, hold: 1'b1};
endpackage

// File: rtl/nco_regfile.sv
`timescale 1ns/1ps
module nco_regfile
  import nco_pkg::*;
#(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12
) (
  input  logic                             clk,
  input  logic                             arst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [ACC_W-1:0]                 wr_data,
  output logic [NUM_SEL-1:0][ACC_W-1:0]    freq_bank,
  output logic [NUM_SEL-1:0][PH_W-1:0]     phase_bank,
  output ctrl_t                            ctrl_s
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                           ctrl_q <= CTRL_RESET;
    else if (wr_en && wr_addr == A_CTRL)   ctrl_q <= ctrl_t'(wr_data[3:0]);
  end

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_bank
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
        freq_bank[g]  <= '0;
        phase_bank[g] <= '0;
      end else if (wr_en) begin
        if (wr_addr == A_FREQ0 + ADDR_W'(g))  freq_bank[g]  <= wr_data;
        if (wr_addr == A_PHASE0 + ADDR_W'(g)) phase_bank[g] <= wr_data[PH_W-1:0];
      end
    end
  end

  // control word enters the core on the falling edge
  always_ff @(negedge clk or negedge arst_n) begin
    if (!arst_n) ctrl_s <= CTRL_RESET;
    else         ctrl_s <= ctrl_q;
  end

  AST_UNUSED_ADDR: assert property (@(posedge clk) disable iff (!arst_n)
    (wr_en && wr_addr > A_LAST) |=> ($stable(freq_bank) && $stable(phase_bank) && $stable(ctrl_q))) // R2
    else $error("write to unused address altered a register");
endmodule

// File: rtl/nco_accum.sv
`timescale 1ns/1ps
module nco_accum
  import nco_pkg::*;
#(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12
) (
  input  logic                          clk,
  input  logic                          arst_n,
  input  logic                          hold,
  input  logic                          sleep,
  input  logic                          fsel,
  input  logic                          psel,
  input  logic [NUM_SEL-1:0][ACC_W-1:0] freq_bank,
  input  logic [NUM_SEL-1:0][PH_W-1:0]  phase_bank,
  output logic [PH_W-1:0]               sum_q
);
  logic [ACC_W-1:0] acc;
  logic [PH_W-1:0]  acc_top;
  logic             psel_q;
  logic [PH_W-1:0]  ph_q;
  logic [ACC_W-1:0] step;

  assign step = freq_bank[fsel];

  // stage 1: accumulator, psel capture
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     acc <= '0;
    else if (hold)   acc <= '0;
    else if (!sleep) acc <= acc + step;
  end

  // stages 2 and 3: align accumulator with the offset, then add
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      psel_q  <= 1'b0;
      ph_q    <= '0;
      acc_top <= '0;
      sum_q   <= '0;
    end else if (hold || !sleep) begin
      psel_q  <= psel;
      ph_q    <= phase_bank[psel_q];
      acc_top <= acc[ACC_W-1 -: PH_W];
      sum_q   <= acc_top + ph_q;
    end
  end

  AST_SLEEP_ACC: assert property (@(posedge clk) disable iff (!arst_n)
    (sleep && !hold) |=> $stable(acc)) // R9
    else $error("accumulator moved during sleep");

  AST_HOLD_ACC: assert property (@(posedge clk) disable iff (!arst_n)
    hold |=> (acc == '0)) // R7
    else $error("accumulator not parked by hold");
endmodule

// File: rtl/nco_outpipe.sv
`timescale 1ns/1ps
module nco_outpipe #(
  parameter int PH_W = 12,
  parameter int LAT  = 7
) (
  input  logic            clk,
  input  logic            arst_n,
  input  logic            hold,
  input  logic            sleep,
  input  logic            div2,
  input  logic            sq_en,
  input  logic [PH_W-1:0] sum_in,
  output logic [PH_W-1:0] phase_out,
  output logic            sq_out
);
  localparam int DLY = LAT - 3;

  logic [LAT-1:0]  vld;
  logic [PH_W-1:0] ph_pipe [DLY];
  logic [DLY-1:0]  sq_pipe;
  logic            msb_prev;
  logic            div_t;
  logic            msb_in;
  logic            rise;

  assign msb_in = sum_in[PH_W-1];
  assign rise   = msb_in & ~msb_prev;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n || hold) begin
      vld      <= '0;
      msb_prev <= 1'b0;
      div_t    <= 1'b0;
    end else if (!sleep) begin
      vld      <= {vld[LAT-2:0], 1'b1};
      msb_prev <= msb_in;
      div_t    <= div_t ^ rise;
    end
  end

  // first delay stage forms the square bit
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ph_pipe[0] <= '0;
      sq_pipe[0] <= 1'b0;
    end else if (hold || !sleep) begin
      ph_pipe[0] <= sum_in;
      sq_pipe[0] <= div2 ? (div_t ^ rise) : msb_in;
    end
  end

  for (genvar i = 1; i < DLY; i++) begin : g_dly
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
        ph_pipe[i] <= '0;
        sq_pipe[i] <= 1'b0;
      end else if (hold || !sleep) begin
        ph_pipe[i] <= ph_pipe[i-1];
        sq_pipe[i] <= sq_pipe[i-1];
      end
    end
  end

  assign phase_out = vld[LAT-1] ? ph_pipe[DLY-1] : '0;
  assign sq_out    = sq_en & vld[LAT-1] & sq_pipe[DLY-1];

  AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!arst_n)
    (sleep && !hold) |=> $stable(phase_out)) // R9
    else $error("output moved during sleep");

  AST_HOLD_BLANK: assert property (@(posedge clk) disable iff (!arst_n)
    hold |=> (phase_out == '0 && !sq_out)) // R7
    else $error("output not blanked by hold");
endmodule

// File: rtl/nco_phase_core.sv
`timescale 1ns/1ps
module nco_phase_core
  import nco_pkg::*;
#(
  parameter int ACC_W   = 28,
  parameter int PH_W    = 12,
  parameter int OUT_LAT = 7
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ACC_W-1:0]  wr_data,
  input  logic              fsel,
  input  logic              psel,
  output logic [PH_W-1:0]   phase_out,
  output logic              sq_out
);
  logic [NUM_SEL-1:0][ACC_W-1:0] freq_bank;
  logic [NUM_SEL-1:0][PH_W-1:0]  phase_bank;
  ctrl_t                         ctrl_s;
  logic [PH_W-1:0]               sum_q;

  nco_regfile #(.ACC_W(ACC_W), .PH_W(PH_W)) u_regs (
    .clk        (clk),
    .arst_n     (arst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .freq_bank  (freq_bank),
    .phase_bank (phase_bank),
    .ctrl_s     (ctrl_s)
  );

  nco_accum #(.ACC_W(ACC_W), .PH_W(PH_W)) u_accum (
    .clk        (clk),
    .arst_n     (arst_n),
    .hold       (ctrl_s.hold),
    .sleep      (ctrl_s.sleep),
    .fsel       (fsel),
    .psel       (psel),
    .freq_bank  (freq_bank),
    .phase_bank (phase_bank),
    .sum_q      (sum_q)
  );

  nco_outpipe #(.PH_W(PH_W), .LAT(OUT_LAT)) u_out (
    .clk       (clk),
    .arst_n    (arst_n),
    .hold      (ctrl_s.hold),
    .sleep     (ctrl_s.sleep),
    .div2      (ctrl_s.div2),
    .sq_en     (ctrl_s.sq_en),
    .sum_in    (sum_q),
    .phase_out (phase_out),
    .sq_out    (sq_out)
  );

  AST_SQ_GATED: assert property (@(posedge clk) disable iff (!arst_n)
    !ctrl_s.sq_en |-> !sq_out) // R10
    else $error("square output driven while disabled");

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!arst_n)
    (ctrl_s.hold && !wr_en) |=> ($stable(freq_bank) && $stable(phase_bank))) // R7
    else $error("hold disturbed stored words");
endmodule

// File: tb/test_nco_phase_core.sv
`timescale 1ns/1ps
module test_nco_phase_core;
  logic        clk = 1'b0;
  logic        arst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [27:0] wr_data;
  logic        fsel, psel;
  logic [11:0] phase_out;
  logic        sq_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  nco_phase_core i_nco_phase_core (
    .clk(clk), .arst_n(arst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fsel(fsel), .psel(psel),
    .phase_out(phase_out), .sq_out(sq_out)
  );

  // {addr, data, psel, expected phase_out} with the accumulator parked at 0
  localparam int NV = 7;
  localparam logic [27:0] VEC [NV] = '{
    {3'd3, 12'h2C4, 1'b0, 12'h2C4},  // R3 offset 0 alone
    {3'd4, 12'h800, 1'b1, 12'h800},  // R3 offset 1
    {3'd4, 12'hFFF, 1'b1, 12'hFFF},  // R3 top value
    {3'd3, 12'h001, 1'b1, 12'hFFF},  // R6 unselected write
    {3'd3, 12'h7AB, 1'b0, 12'h7AB},  // R3 back to offset 0
    {3'd5, 12'h3FF, 1'b0, 12'h7AB},  // R2 unused address
    {3'd4, 12'h555, 1'b0, 12'h7AB}   // R6 unselected write
  };

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [27:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic measure(output int highs, output int maxrun);
    int run = 0;
    highs = 0; maxrun = 0;
    for (int i = 0; i < 64; i++) begin
      step();
      if (sq_out) begin
        highs++; run++;
        if (run > maxrun) maxrun = run;
      end else run = 0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [11:0] q;
    int hi, mr;
    arst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; fsel = 1'b0; psel = 1'b0;
    repeat (3) step();
    arst_n = 1'b1;
    chk("R1 phase after reset", phase_out, 0);
    chk("R1 square after reset", sq_out, 0);
    repeat (10) step();
    chk("R1 held until released", phase_out, 0);

    // setup and release (R8)
    wr(3'd3, 28'h100);
    wr(3'd1, 28'h0);
    wr(3'd2, 28'h10000);
    wr(3'd4, 28'h0);
    wr(3'd0, 28'h4);
    repeat (6) step();
    chk("R8 blank through edge k+6", phase_out, 0);
    step();
    chk("R8 first output at k+7", phase_out, 12'h100);

    // vector walk
    for (int v = 0; v < NV; v++) begin
      wr(VEC[v][27:25], {16'h0, VEC[v][24:13]});
      psel = VEC[v][12];
      repeat (10) step();
      chk($sformatf("R3/R2/R6 vector %0d", v), phase_out, VEC[v][11:0]);
    end

    // psel latency (R5)
    psel = 1'b1;
    repeat (6) step();
    chk("R5 psel before due edge", phase_out, 12'h7AB);
    step();
    chk("R5 psel on seventh edge", phase_out, 12'h555);

    // phase offset write latency (R6)
    wr(3'd4, 28'h0AA);
    repeat (5) step();
    chk("R6 phase write before due edge", phase_out, 12'h555);
    step();
    chk("R6 phase write on seventh edge", phase_out, 12'h0AA);

    // tuning word write latency (R6)
    wr(3'd1, 28'h10000);
    repeat (6) step();
    chk("R6 tuning write before due edge", phase_out, 12'h0AA);
    step();
    chk("R6 tuning write on eighth edge", phase_out, 12'h0AB);
    step();
    chk("R3 one step per cycle", phase_out, 12'h0AC);

    // fsel latency (R4)
    wr(3'd1, 28'h0);
    repeat (10) step();
    q = phase_out;
    fsel = 1'b1;
    repeat (6) step();
    chk("R4 fsel before due edge", phase_out, q);
    step();
    q = q + 12'd1;
    chk("R4 fsel on seventh edge", phase_out, q);
    for (int i = 0; i < 4; i++) begin
      step();
      q = q + 12'd1;
      chk("R3 steady increment", phase_out, q);
    end

    // sleep (R9)
    wr(3'd0, 28'h6);
    q = phase_out;
    repeat (5) step();
    chk("R9 frozen during sleep", phase_out, q);
    wr(3'd0, 28'h4);
    chk("R9 still frozen on clearing edge", phase_out, q);
    step();
    chk("R9 resumes from frozen value", phase_out, q + 12'd1);

    // hold (R7)
    fsel = 1'b0;
    wr(3'd0, 28'h5);
    step();
    chk("R7 phase blanked by hold", phase_out, 0);
    chk("R7 square blanked by hold", sq_out, 0);
    repeat (5) step();
    wr(3'd0, 28'h4);
    repeat (6) step();
    chk("R8 blank after hold release", phase_out, 0);
    step();
    chk("R7 offset kept, accumulator cleared", phase_out, 12'h0AA);

    // square output (R10, R11)
    wr(3'd1, 28'h1000000);
    repeat (20) step();
    measure(hi, mr);
    chk("R10 square high count", hi, 32);
    chk("R10 square run length", mr, 8);
    wr(3'd0, 28'hC);
    repeat (40) step();
    measure(hi, mr);
    chk("R11 halved square high count", hi, 32);
    chk("R11 halved square run length", mr, 16);
    wr(3'd0, 28'h0);
    repeat (10) step();
    measure(hi, mr);
    chk("R10 square off when disabled", hi, 0);

    summary();
    $finish;
  end
endmodule